// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block produces one pulse-width-modulated output. The time base is an 8-bit period timer fed by a selectable prescaler. The timer is extended by two fine-count bits taken from the prescaler, which gives a 10-bit duty comparison. Software programs three registers through a write-only register port: the period, the upper 8 duty bits, and a control byte. The control byte holds the prescaler select, the run enable and the lower 2 duty bits.

A full PWM period lasts (period+1)·4·N clocks, where N is the prescale ratio. One duty step lasts N clocks. The duty and period values that software writes are only pending copies. The active values are captured at each period boundary and when the block is enabled, so a write made in the middle of a period never distorts the pulse that is running. A sticky match flag records every period boundary and is cleared by a strobe.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset the output and the match flag are low, the block is disabled, the pending period is 0xFF and the prescaler is 1:1.
- R2: Writes with wr_en_i high update registers by address. Address 0 is the period, address 1 is duty bits [9:2], address 2 is the control byte. The control byte holds the prescaler select in bits [1:0] (00 gives ÷1, 01 gives ÷4, 10 and 11 give ÷16), the enable in bit 2 and duty bits [1:0] in bits [4:3]. Address 3 is ignored.
- R3: While enabled, one PWM period lasts (period+1)·4·N clocks.
- R4: Each period starts high at the boundary and stays high for exactly duty·N clocks. The fine count is prescaler bits [1:0], [3:2] or [5:4] for ÷1, ÷4 or ÷16.
- R5: A duty write made while running does not change the pulse in progress. It takes effect from the next period boundary.
- R6: A period write made while running takes effect from the next period boundary.
- R7: A duty value above the last position of the period, {period, 2'b11}, keeps the output high for the whole period.
- R8: A duty of 0 keeps the output low.
- R9: The match flag is set at each period boundary and stays set until a flag_clr_i strobe. A boundary in the same cycle as the strobe wins.
- R10: Enabling the block loads the pending duty and period and starts a period from timer 0 on that same edge. Disabling it returns the timer to 0 and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| flag_clr_i | input | 1 | Clears the match flag |
| pwm_o | output | 1 | PWM output |
| match_flag_o | output | 1 | Sticky period-boundary flag |

## Verification
A wrong shadow duty or a wrong fine-count selection does not show as a short glitch. It shows as a high-time count over a full period that differs from duty·N, and the difference appears within one period of a few hundred to a few thousand clocks. A buffering fault shows when a write is made mid-period: the high count of the period already in progress changes, or the period length changes before the boundary. A timer or boundary fault moves the edge at which match_flag_o rises away from (period+1)·4·N clocks after enable.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int FINE_W = 2;

  localparam logic [1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [1:0] ADDR_DUTY_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL    = 2'd2;

  localparam int CTRL_EN_BIT = 2;
  localparam int CTRL_LO_LSB = 3;

  typedef enum logic [1:0] {
    PRESC_1   = 2'b00,
    PRESC_4   = 2'b01,
    PRESC_16  = 2'b10,
    PRESC_16B = 2'b11
  } presc_e;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  localparam int DUTY_W = TMR_W + FINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [TMR_W-1:0]  wr_data_i,
  input  logic              flag_clr_i,
  input  logic              boundary_i,
  output logic [TMR_W-1:0]  pr_o,
  output logic [DUTY_W-1:0] duty_pend_o,
  output presc_e            presc_o,
  output logic              en_o,
  output logic              start_o,
  output logic              flag_o
);
  logic [TMR_W-1:0]  pr_q, dhi_q;
  logic [FINE_W-1:0] dlo_q;
  logic [1:0]        sel_q;
  logic              en_q, flag_q, ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign start_o = ctrl_wr && wr_data_i[CTRL_EN_BIT] && !en_q;

  // at enable the low duty bits come straight from the write data
  assign duty_pend_o = start_o ? {dhi_q, wr_data_i[CTRL_LO_LSB +: FINE_W]}
                               : {dhi_q, dlo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_q   <= '1;
      dhi_q  <= '0;
      dlo_q  <= '0;
      sel_q  <= PRESC_1;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_PERIOD)  pr_q  <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADDR_DUTY_HI) dhi_q <= wr_data_i;
      if (ctrl_wr) begin
        sel_q <= wr_data_i[1:0];
        en_q  <= wr_data_i[CTRL_EN_BIT];
        dlo_q <= wr_data_i[CTRL_LO_LSB +: FINE_W];
      end
      if (boundary_i)      flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign pr_o    = pr_q;
  assign presc_o = presc_e'(sel_q);
  assign en_o    = en_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  localparam int DUTY_W = TMR_W + FINE_W,
  localparam int PRE_W  = FINE_W * 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  presc_e            presc_i,
  input  logic [TMR_W-1:0]  pr_i,
  output logic [TMR_W-1:0]  tmr_o,
  output logic [TMR_W-1:0]  pr_act_o,
  output logic              boundary_o,
  output logic [DUTY_W-1:0] pos_nxt_o
);
  localparam logic [PRE_W-1:0] M1  = PRE_W'((1 << FINE_W) - 1);
  localparam logic [PRE_W-1:0] M4  = PRE_W'((1 << (2*FINE_W)) - 1);
  localparam logic [PRE_W-1:0] M16 = PRE_W'((1 << (3*FINE_W)) - 1);

  logic [PRE_W-1:0]  pre_q, pre_n, mask;
  logic [TMR_W-1:0]  tmr_q, tmr_n, pr_q;
  logic [FINE_W-1:0] fine_n;
  logic              step;

  always_comb begin
    unique case (presc_i)
      PRESC_1:  mask = M1;
      PRESC_4:  mask = M4;
      default:  mask = M16;
    endcase
    step       = en_i && ((pre_q & mask) == mask);
    boundary_o = step && (tmr_q == pr_q);
    if (!en_i) begin
      pre_n = '0;
      tmr_n = '0;
    end else if (step) begin
      pre_n = '0;
      tmr_n = boundary_o ? '0 : tmr_q + 1'b1;
    end else begin
      pre_n = pre_q + 1'b1;
      tmr_n = tmr_q;
    end
    unique case (presc_i)
      PRESC_1:  fine_n = pre_n[FINE_W-1:0];
      PRESC_4:  fine_n = pre_n[2*FINE_W-1:FINE_W];
      default:  fine_n = pre_n[3*FINE_W-1:2*FINE_W];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      tmr_q <= '0;
      pr_q  <= '1;
    end else begin
      pre_q <= pre_n;
      tmr_q <= tmr_n;
      if (start_i || boundary_o) pr_q <= pr_i;
    end
  end

  assign tmr_o     = tmr_q;
  assign pr_act_o  = pr_q;
  assign pos_nxt_o = {tmr_n, fine_n};
endmodule

// File: rtl/pwm_dbuf_compare.sv
module pwm_dbuf_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              boundary_i,
  input  logic [DUTY_W-1:0] pos_nxt_i,
  input  logic [DUTY_W-1:0] duty_pend_i,
  output logic [DUTY_W-1:0] shadow_o,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] shadow_q;
  logic              out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      out_q    <= 1'b0;
    end else if (start_i || boundary_i) begin
      shadow_q <= duty_pend_i;
      out_q    <= (duty_pend_i != '0);
    end else if (!en_i) begin
      out_q <= 1'b0;
    end else if (pos_nxt_i == shadow_q) begin
      // equality on the next position: clears exactly duty*N clocks in
      out_q <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign pwm_o    = out_q;
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W  = 8,
  localparam int DUTY_W = TMR_W + FINE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic             pwm_o,
  output logic             match_flag_o
);
  logic [TMR_W-1:0]  pr_pend, tmr, pr_act;
  logic [DUTY_W-1:0] duty_pend, pos_nxt, shadow;
  presc_e            presc;
  logic              en, start, boundary;

  pwm_dbuf_regs #(.TMR_W(TMR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .flag_clr_i,
    .boundary_i  (boundary),
    .pr_o        (pr_pend),
    .duty_pend_o (duty_pend),
    .presc_o     (presc),
    .en_o        (en),
    .start_o     (start),
    .flag_o      (match_flag_o)
  );

  pwm_dbuf_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk_i, .rst_ni,
    .en_i       (en),
    .start_i    (start),
    .presc_i    (presc),
    .pr_i       (pr_pend),
    .tmr_o      (tmr),
    .pr_act_o   (pr_act),
    .boundary_o (boundary),
    .pos_nxt_o  (pos_nxt)
  );

  pwm_dbuf_compare #(.DUTY_W(DUTY_W)) u_cmp (
    .clk_i, .rst_ni,
    .en_i        (en),
    .start_i     (start),
    .boundary_i  (boundary),
    .pos_nxt_i   (pos_nxt),
    .duty_pend_i (duty_pend),
    .shadow_o    (shadow),
    .pwm_o       (pwm_o)
  );
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
  parameter int TMR_W  = 8,
  localparam int DUTY_W = TMR_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              start_i,
  input logic              boundary_i,
  input logic [DUTY_W-1:0] duty_pend_i,
  input logic [DUTY_W-1:0] shadow_i,
  input logic [TMR_W-1:0]  tmr_i,
  input logic [TMR_W-1:0]  pr_act_i,
  input logic              pwm_i,
  input logic              flag_i,
  input logic              flag_clr_i
);
  a_r3_timer_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> tmr_i <= pr_act_i);
  a_r4_rise_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && duty_pend_i != '0) |=> pwm_i);
  a_r5_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boundary_i && !start_i) |=> $stable(shadow_i));
  a_r6_period_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boundary_i && !start_i) |=> $stable(pr_act_i));
  a_r8_zero_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_i == '0 && !boundary_i && !start_i) |=> !pwm_i);
  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> flag_i);
  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !flag_clr_i) |=> flag_i);
  a_r9_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !boundary_i) |=> !flag_i);
  a_r10_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> !pwm_i);
endmodule

bind pwm_dbuf pwm_dbuf_chk #(.TMR_W(TMR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en),
  .start_i     (start),
  .boundary_i  (boundary),
  .duty_pend_i (duty_pend),
  .shadow_i    (shadow),
  .tmr_i       (tmr),
  .pr_act_i    (pr_act),
  .pwm_i       (pwm_o),
  .flag_i      (match_flag_o),
  .flag_clr_i  (flag_clr_i)
);

// File: tb/pwm_dbuf_tb.sv
`timescale 1ns/1ps
module pwm_dbuf_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       flag_clr = 1'b0;
  logic       pwm, flag;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_dbuf u_dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .flag_clr_i (flag_clr),
    .pwm_o (pwm), .match_flag_o (flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm) c++;
    end
  endtask

  task automatic stop_run();
    wr(2'd2, 8'h00);
    repeat (2) @(negedge clk);
  endtask

  // ctrl: [1:0] prescale, [2] enable, [4:3] duty low bits
  task automatic start_run(input logic [7:0] pr, input logic [7:0] hi, input logic [7:0] ctrl);
    wr(2'd0, pr);
    wr(2'd1, hi);
    wr(2'd2, ctrl);
  endtask

  task automatic t_reset();
    check(pwm == 1'b0, "R1 pwm after reset", pwm, 0);
    check(flag == 1'b0, "R1 flag after reset", flag, 0);
  endtask

  task automatic t_default_period();
    int c;
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h04);               // default period 0xFF, 1:1
    count_high(1024, c);
    check(c == 256, "R1 R3 R4 default period high count", c, 256);
    wr(2'd3, 8'hFF);               // address 3 ignored
    count_high(1024, c);
    check(c == 256, "R2 addr3 ignored", c, 256);
    stop_run();
  endtask

  task automatic t_div4();
    int c;
    start_run(8'h3F, 8'h29, 8'h0D); // duty 0x0A5, /4
    count_high(1024, c);
    check(c == 660, "R2 R4 div4 high count", c, 660);
    stop_run();
  endtask

  task automatic t_div16();
    int c;
    start_run(8'h1F, 8'h1F, 8'h1E); // duty 0x07F, /16
    count_high(2048, c);
    check(c == 2032, "R3 R4 div16 high count", c, 2032);
    count_high(2048, c);
    check(c == 2032, "R4 div16 second period", c, 2032);
    stop_run();
  endtask

  task automatic t_over();
    int c;
    start_run(8'h1F, 8'h40, 8'h04); // duty 0x100 > 0x7F
    count_high(256, c);
    check(c == 256, "R7 duty above period stays high", c, 256);
    stop_run();
  endtask

  task automatic t_zero();
    int c;
    start_run(8'h1F, 8'h00, 8'h04);
    count_high(256, c);
    check(c == 0, "R8 zero duty stays low", c, 0);
    stop_run();
  endtask

  task automatic t_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(flag == 1'b0, "R9 flag cleared", flag, 0);
    start_run(8'h1F, 8'h10, 8'h04); // period 128 clocks
    check(flag == 1'b0, "R9 flag low at start", flag, 0);
    repeat (127) @(negedge clk);
    check(flag == 1'b0, "R3 R9 flag before boundary", flag, 0);
    @(negedge clk);
    check(flag == 1'b1, "R3 R9 flag at boundary", flag, 1);
    repeat (10) @(negedge clk);
    check(flag == 1'b1, "R9 flag sticky", flag, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(flag == 1'b0, "R9 flag strobe clear", flag, 0);
    stop_run();
  endtask

  task automatic t_duty_buf();
    int c;
    start_run(8'h3F, 8'h10, 8'h04); // duty 0x40, 256-clock period; R10 load at enable
    fork
      count_high(256, c);
      begin repeat (100) @(negedge clk); wr(2'd1, 8'h30); end
    join
    check(c == 64, "R5 R10 duty held mid-period", c, 64);
    count_high(256, c);
    check(c == 192, "R5 new duty next period", c, 192);
    stop_run();
  endtask

  task automatic t_pr_buf();
    int c;
    start_run(8'h3F, 8'h10, 8'h04);
    fork
      count_high(256, c);
      begin repeat (100) @(negedge clk); wr(2'd0, 8'h1F); end
    join
    check(c == 64, "R6 period held mid-period", c, 64);
    count_high(128, c);
    check(c == 64, "R6 new period applied", c, 64);
    count_high(128, c);
    check(c == 64, "R6 new period repeats", c, 64);
    stop_run();
  endtask

  task automatic t_disable();
    int c;
    start_run(8'h1F, 8'h60, 8'h04);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'h00);
    @(negedge clk);
    count_high(300, c);
    check(c == 0, "R10 disabled output low", c, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_period();
    t_div4();
    t_div16();
    t_over();
    t_zero();
    t_flag();
    t_duty_buf();
    t_pr_buf();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule